// File: doc/BRIEF.md
# Selectable-Timebase 16-bit Counter

This block is a free-running 16-bit up-counter. A 3-bit select input picks the event that advances it. Three of the events come from the system clock: every cycle, every fourth cycle, or every twelfth cycle. One comes from a second, independent oscillator that is divided by eight in its own clock domain and then carried across into the system domain. The last two are event inputs: an overflow strobe from a neighbouring timer, and an asynchronous count pin from outside the chip.

The counter has a run enable and a load port that overwrites it in one cycle. When the count wraps from all ones to zero, the block raises a single-cycle overflow pulse and sets a sticky overflow flag. The flag stays set until a clear strobe arrives. A surrounding timer subsystem uses the count as its common timebase and uses the pulse or the flag to mark periods.

Top module: `tbase_counter`

## Requirements
- R1: While synchronous reset `rst` is high, the count, the overflow pulse, the overflow flag and every prescaler and edge-detector state are cleared; after reset the outputs read count 0, pulse 0 and flag 0.
- R2: With `src_sel` = 0 and `run_en` high, the count advances by exactly one on every system clock edge. In no cycle without a load does the count change by anything other than 0 or +1.
- R3: With `src_sel` = 1 the count advances exactly once per 4 system clocks. With `src_sel` = 2 it advances exactly once per 12 system clocks. Over any run window whose length is a multiple of the divisor, the advance is the window length divided by the divisor.
- R4: With `src_sel` = 3 the count advances once for every 8 cycles of `osc_clk`. That clock is divided in its own domain and synchronized into the system domain through two flops.
- R5: With `src_sel` = 4 the count advances by one for each system-clock cycle in which `t0_ovf` is high.
- R6: With `src_sel` = 5 the count advances by one for each rising edge on `ext_cnt`. The pin is synchronized through two flops, and each level must last at least two system clocks.
- R7: Select codes 6 and 7 produce no count events, so the count holds.
- R8: While `run_en` is low and no load is applied, the count holds.
- R9: When `load_stb` is high, the count takes `load_val` on the next edge, whatever the run and source state. No increment and no overflow happen in that cycle.
- R10: When an increment takes the count from 0xFFFF to 0x0000, `ovf_pulse` is high for exactly the one cycle after that edge, and `ovf_flag` is set.
- R11: `ovf_flag` stays set until an edge where `ovf_clr` is high clears it. If a wrap and `ovf_clr` occur in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Count enable |
| src_sel | input | 3 | Timebase select, codes 0 to 7 |
| osc_clk | input | 1 | Independent oscillator clock |
| t0_ovf | input | 1 | Neighbour timer overflow strobe, system domain |
| ext_cnt | input | 1 | Asynchronous external count pin |
| load_stb | input | 1 | Load strobe |
| load_val | input | 16 | Value written on load |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| count | output | 16 | Current count |
| ovf_pulse | output | 1 | One-cycle wrap indication |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
The counting path is tried with each system-clock rate over windows that are whole multiples of the divisor. An exact delta therefore separates a correct /4 or /12 prescaler from one that is off by one cycle or runs at the wrong rate. The reserved codes and the disabled state use the same windows and must give a zero delta, which shows that they are not aliased onto another source. The oscillator source is judged against a narrow range, because its phase relative to the system clock is free. Pulse trains on the timer strobe and on the pin must each give their exact number of events. The pin train shows that one rising edge counts once rather than once per high cycle.

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int WIDTH   = 16,
  parameter int DIV_A   = 4,
  parameter int DIV_B   = 12,
  parameter int OSC_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [2:0]       src_sel,
  input  logic             osc_clk,
  input  logic             t0_ovf,
  input  logic             ext_cnt,
  input  logic             load_stb,
  input  logic [WIDTH-1:0] load_val,
  input  logic             ovf_clr,
  output logic [WIDTH-1:0] count,
  output logic             ovf_pulse,
  output logic             ovf_flag
);
  localparam int AW = $clog2(DIV_A);
  localparam int BW = $clog2(DIV_B);
  localparam int OW = $clog2(OSC_DIV);

  logic [AW-1:0] pre_a;
  logic [BW-1:0] pre_b;
  logic tick_a, tick_b;

  assign tick_a = (pre_a == AW'(DIV_A - 1));
  assign tick_b = (pre_b == BW'(DIV_B - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_a <= '0;
      pre_b <= '0;
    end else begin
      pre_a <= tick_a ? '0 : pre_a + 1'b1;
      pre_b <= tick_b ? '0 : pre_b + 1'b1;
    end
  end

  logic [1:0]    orst_q;
  logic [OW-1:0] osc_cnt;
  logic          osc_div_q;

  always_ff @(posedge osc_clk) begin
    orst_q <= {orst_q[0], rst};
    if (orst_q[1]) begin
      osc_cnt   <= '0;
      osc_div_q <= 1'b0;
    end else begin
      osc_cnt   <= (osc_cnt == OW'(OSC_DIV - 1)) ? '0 : osc_cnt + 1'b1;
      osc_div_q <= (osc_cnt >= OW'(OSC_DIV / 2 - 1)) && (osc_cnt != OW'(OSC_DIV - 1));
    end
  end

  logic [2:0] osc_sync;
  logic [2:0] pin_sync;
  logic tick_osc, tick_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_sync <= '0;
      pin_sync <= '0;
    end else begin
      osc_sync <= {osc_sync[1:0], osc_div_q};
      pin_sync <= {pin_sync[1:0], ext_cnt};
    end
  end

  assign tick_osc = osc_sync[1] & ~osc_sync[2];
  assign tick_pin = pin_sync[1] & ~pin_sync[2];

  logic tick;
  always_comb begin
    case (src_sel)
      3'd0:    tick = 1'b1;
      3'd1:    tick = tick_a;
      3'd2:    tick = tick_b;
      3'd3:    tick = tick_osc;
      3'd4:    tick = t0_ovf;
      3'd5:    tick = tick_pin;
      default: tick = 1'b0;
    endcase
  end

  logic step, wrap;
  assign step = ~load_stb & run_en & tick;
  assign wrap = step & (&count);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      ovf_pulse <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      if (load_stb)  count <= load_val;
      else if (step) count <= count + 1'b1;
      if (wrap)         ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tbase_counter_chk.sv
module tbase_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic [2:0]       src_sel,
  input logic             load_stb,
  input logic [WIDTH-1:0] load_val,
  input logic             ovf_clr,
  input logic [WIDTH-1:0] count,
  input logic             ovf_pulse,
  input logic             ovf_flag
);
  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> count == $past(load_val));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !run_en) |=> $stable(count));

  a_r7_reserved_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && src_sel[2:1] == 2'b11) |=> $stable(count));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> (count == $past(count) || count == $past(count) + 1'b1));

  a_r10_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (count == '0 && ovf_flag));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse);

  a_r11_flag_from_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ovf_pulse);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind tbase_counter tbase_counter_chk #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rst(rst), .run_en(run_en), .src_sel(src_sel),
  .load_stb(load_stb), .load_val(load_val), .ovf_clr(ovf_clr),
  .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
);

// File: tb/tbase_counter_test.sv
`timescale 1ns/1ps
module tbase_counter_test;
  logic        clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [2:0]  src_sel = 3'd0;
  logic        t0_ovf = 1'b0;
  logic        ext_cnt = 1'b0;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = 16'h0;
  logic        ovf_clr = 1'b0;
  logic [15:0] count;
  logic        ovf_pulse, ovf_flag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;
  always #4 osc_clk = ~osc_clk;

  tbase_counter uut (
    .clk(clk), .rst(rst), .run_en(run_en), .src_sel(src_sel),
    .osc_clk(osc_clk), .t0_ovf(t0_ovf), .ext_cnt(ext_cnt),
    .load_stb(load_stb), .load_val(load_val), .ovf_clr(ovf_clr),
    .count(count), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
  );

  localparam int NV = 9;
  localparam int VSEL [NV] = '{0, 1, 2, 6, 7, 1, 2, 0, 3};
  localparam int VCYC [NV] = '{20, 48, 48, 30, 30, 24, 36, 7, 0};
  localparam int VEXP [NV] = '{20, 12, 4, 0, 0, 6, 3, 7, 0};

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic load(input logic [15:0] v);
    load_val = v; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic run(input int n);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
    run_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    check("R1 count after reset", count, 0);
    check("R1 pulse after reset", ovf_pulse, 0);
    check("R1 flag after reset", ovf_flag, 0);

    // R2 R3 R7: windows sized to whole divisor periods; sel 3 entry is skipped
    for (int i = 0; i < NV; i++) begin
      if (VCYC[i] == 0) continue;
      load(16'h0);
      src_sel = 3'(VSEL[i]);
      run(VCYC[i]);
      check($sformatf("R2/R3/R7 sel %0d over %0d cycles", VSEL[i], VCYC[i]), count, VEXP[i]);
    end

    // R8: run disabled, clock source
    load(16'h0100);
    src_sel = 3'd0;
    repeat (10) @(negedge clk);
    check("R8 hold with run low", count, 16'h0100);

    // R4: oscillator /8, 130 system cycles = 650 ns, about 10 events
    load(16'h0);
    src_sel = 3'd3;
    repeat (20) @(negedge clk);
    run(130);
    checks++;
    if (count < 9 || count > 12) begin
      fails++;
      $display("FAIL R4 oscillator events: got %0d expected 10", count);
    end

    // R5: neighbour overflow strobes, one per high cycle
    load(16'h0);
    src_sel = 3'd4;
    run_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      t0_ovf = 1'b1; @(negedge clk);
      t0_ovf = 1'b0; repeat (3) @(negedge clk);
    end
    t0_ovf = 1'b1; repeat (2) @(negedge clk);
    t0_ovf = 1'b0; repeat (2) @(negedge clk);
    run_en = 1'b0;
    check("R5 strobe events", count, 7);

    // R6: pin edges, three cycles per level
    load(16'h0);
    src_sel = 3'd5;
    run_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      ext_cnt = 1'b1; repeat (3) @(negedge clk);
      ext_cnt = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    run_en = 1'b0;
    check("R6 pin rising edges", count, 4);

    // R9: load beats counting
    src_sel = 3'd0;
    run_en = 1'b1;
    load(16'h1234);
    run_en = 1'b0;
    check("R9 load priority value", count, 16'h1234);
    run_en = 1'b1;
    load(16'hFFFF);
    run_en = 1'b0;
    check("R9 load of all ones", count, 16'hFFFF);
    check("R9 no pulse on load", ovf_pulse, 0);
    check("R9 no flag on load", ovf_flag, 0);

    // R10: wrap
    load(16'hFFFE);
    run(2);
    check("R10 count wraps", count, 0);
    check("R10 pulse after wrap", ovf_pulse, 1);
    check("R10 flag after wrap", ovf_flag, 1);
    @(negedge clk);
    check("R10 pulse one cycle", ovf_pulse, 0);

    // R11: sticky flag, clear, and set beating clear
    repeat (5) @(negedge clk);
    check("R11 flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R11 flag cleared", ovf_flag, 0);
    load(16'hFFFF);
    ovf_clr = 1'b1;
    run(1);
    ovf_clr = 1'b0;
    check("R11 set wins over clear", ovf_flag, 1);

    // R1: reset mid-run
    load(16'h0777);
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    check("R1 count cleared", count, 0);
    check("R1 flag cleared", ovf_flag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule